// File: doc/BRIEF.md
# One-Hot Selected Bus Demultiplexer

This block sits between one Wishbone bus master and a parameterised set of target slaves. A one-hot select vector arrives next to the master's signals. It comes from an address decoder outside the block. The block uses it to decide which target sees the cycle and strobe. Address, write data, write enable and byte lanes are copied to every target. Only the chosen target is given `cyc` and `stb`. Its acknowledge, error, retry and read data travel back to the master in the same cycle, through combinational logic.

The choice of target is taken from the live select vector in the first cycle of a strobe, then frozen for the rest of that access. The frozen choice is released when the access ends: the strobe drops, the cycle drops, or any termination reaches the master. The master can therefore change the select vector partway through an access without moving the access. It can also aim its next strobe at a different target, whether or not it keeps `cyc` asserted in between. A select vector that is all zero, or that has more than one bit set, strobes no target. The master then sees a quiet bus.

Top module: `demux_onehot`

## Requirements
- R1: Address, write data, write enable and byte-enable reach every target unchanged, in the same cycle, whichever target is selected.
- R2: At most one target sees `stb` at any time, and a target never sees `stb` without also seeing `cyc`.
- R3: In the first cycle that the master drives `cyc` and `stb` with a select vector that has exactly one bit set (bit i meaning target i), target i sees `cyc` and `stb` in that same cycle and every other target sees `stb` low.
- R4: The strobed target's ack, err, rty and read data are presented to the master in the same cycle that the target drives them.
- R5: Once a strobe has started, changes to the select vector, including a change to all zero, are ignored until that access terminates or the strobe drops.
- R6: When the master drops `stb` but keeps `cyc` high and then strobes again, the new strobe goes to the target named by the select vector at that moment.
- R7: When the master releases `cyc` and then begins a new cycle, the new cycle goes to the newly selected target.
- R8: With an all-zero select vector no target is strobed. The master then sees ack, err and rty low and read data zero.
- R9: A select vector with two or more bits set is handled like an all-zero one: no target is strobed and all responses stay low.
- R10: Responses driven by targets that are not strobed never reach the master.
- R11: When an access terminates while the master holds `stb` high, the next cycle is a new access that takes the live select vector.
- R12: After reset, while the master is idle, no target sees `cyc` or `stb` and the master sees no response.

Top module ports are listed below; per-target buses are packed, with target i in slice i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc_i | input | 1 | Master bus cycle |
| m_stb_i | input | 1 | Master strobe |
| m_we_i | input | 1 | Master write enable |
| m_adr_i | input | ADDR_W | Master address |
| m_dat_i | input | DATA_W | Master write data |
| m_be_i | input | BE_W | Master byte lane enables |
| m_tsel_i | input | NUM_TGT | One-hot target select |
| m_ack_o | output | 1 | Acknowledge to master |
| m_err_o | output | 1 | Error to master |
| m_rty_o | output | 1 | Retry to master |
| m_dat_o | output | DATA_W | Read data to master |
| t_cyc_o | output | NUM_TGT | Per-target cycle |
| t_stb_o | output | NUM_TGT | Per-target strobe |
| t_we_o | output | NUM_TGT | Per-target write enable |
| t_adr_o | output | NUM_TGT*ADDR_W | Per-target address |
| t_dat_o | output | NUM_TGT*DATA_W | Per-target write data |
| t_be_o | output | NUM_TGT*BE_W | Per-target byte enables |
| t_ack_i | input | NUM_TGT | Per-target acknowledge |
| t_err_i | input | NUM_TGT | Per-target error |
| t_rty_i | input | NUM_TGT | Per-target retry |
| t_dat_i | input | NUM_TGT*DATA_W | Per-target read data |

## Verification
Two things can happen in the same clock edge: an access terminates, and a new select value tries to take effect. The frozen choice has to let go exactly on the terminating edge, and not one edge early or late. The bench tests this with a directed sequence. It first changes the select vector in the middle of a held strobe. It then terminates the access with `stb` kept high, so the next cycle must pick up the new vector. In each cycle it checks which target sees `stb` and which response reaches the master. Around this, every 4-bit select value is swept against all three response types, with every target answering. This shows that only the strobed target's response gets through.

// File: rtl/demux_pkg.sv
package demux_pkg;

  localparam int unsigned MAX_TGT = 64;

  // True when exactly one bit of the vector is set.
  function automatic logic single_bit(input logic [MAX_TGT-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_TGT; i++) begin
      n = n + int'(v[i]);
    end
    return (n == 1);
  endfunction

endpackage

// File: rtl/demux_rst_sync.sv
module demux_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/demux_sel_hold.sv
module demux_sel_hold #(
  parameter int unsigned NUM_TGT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic [NUM_TGT-1:0] tsel_i,
  input  logic               term_i,
  output logic [NUM_TGT-1:0] route_o
);

  logic               legal;
  logic [NUM_TGT-1:0] live_route;
  logic               active;
  logic               start;

  logic               hold_q, hold_d;
  logic [NUM_TGT-1:0] sel_q;
  logic               sel_en;

  assign legal      = demux_pkg::single_bit(demux_pkg::MAX_TGT'(tsel_i));
  assign live_route = legal ? tsel_i : '0;
  assign active     = cyc_i & stb_i;
  assign start      = active & ~hold_q;

  // Next state: hold the captured target while the access is still open.
  always_comb begin
    hold_d = hold_q;
    if (!active) begin
      hold_d = 1'b0;
    end else if (term_i) begin
      hold_d = 1'b0;
    end else begin
      hold_d = 1'b1;
    end
    sel_en = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= live_route;
    end
  end

  assign route_o = hold_q ? sel_q : live_route;

endmodule

// File: rtl/demux_fwd.sv
module demux_fwd #(
  parameter int unsigned NUM_TGT = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BE_W    = 4
) (
  input  logic                      cyc_i,
  input  logic                      stb_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         adr_i,
  input  logic [DATA_W-1:0]         dat_i,
  input  logic [BE_W-1:0]           be_i,
  input  logic [NUM_TGT-1:0]        route_i,
  output logic [NUM_TGT-1:0]        t_cyc_o,
  output logic [NUM_TGT-1:0]        t_stb_o,
  output logic [NUM_TGT-1:0]        t_we_o,
  output logic [NUM_TGT*ADDR_W-1:0] t_adr_o,
  output logic [NUM_TGT*DATA_W-1:0] t_dat_o,
  output logic [NUM_TGT*BE_W-1:0]   t_be_o
);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    assign t_cyc_o[g]                   = cyc_i & route_i[g];
    assign t_stb_o[g]                   = cyc_i & stb_i & route_i[g];
    assign t_we_o[g]                    = we_i;
    assign t_adr_o[g*ADDR_W +: ADDR_W]  = adr_i;
    assign t_dat_o[g*DATA_W +: DATA_W]  = dat_i;
    assign t_be_o[g*BE_W +: BE_W]       = be_i;
  end

endmodule

// File: rtl/demux_ret.sv
module demux_ret #(
  parameter int unsigned NUM_TGT = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [NUM_TGT-1:0]        strobed_i,
  input  logic [NUM_TGT-1:0]        t_ack_i,
  input  logic [NUM_TGT-1:0]        t_err_i,
  input  logic [NUM_TGT-1:0]        t_rty_i,
  input  logic [NUM_TGT*DATA_W-1:0] t_dat_i,
  output logic                      ack_o,
  output logic                      err_o,
  output logic                      rty_o,
  output logic [DATA_W-1:0]         dat_o
);

  logic [DATA_W-1:0] masked [NUM_TGT];

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_mask
    assign masked[g] = t_dat_i[g*DATA_W +: DATA_W] & {DATA_W{strobed_i[g]}};
  end

  // AND-OR tree: one level of masking, then an OR reduction.
  always_comb begin
    dat_o = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      dat_o = dat_o | masked[i];
    end
    ack_o = |(t_ack_i & strobed_i);
    err_o = |(t_err_i & strobed_i);
    rty_o = |(t_rty_i & strobed_i);
  end

endmodule

// File: rtl/demux_onehot.sv
module demux_onehot #(
  parameter int unsigned NUM_TGT = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BE_W    = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      m_cyc_i,
  input  logic                      m_stb_i,
  input  logic                      m_we_i,
  input  logic [ADDR_W-1:0]         m_adr_i,
  input  logic [DATA_W-1:0]         m_dat_i,
  input  logic [BE_W-1:0]           m_be_i,
  input  logic [NUM_TGT-1:0]        m_tsel_i,
  output logic                      m_ack_o,
  output logic                      m_err_o,
  output logic                      m_rty_o,
  output logic [DATA_W-1:0]         m_dat_o,
  output logic [NUM_TGT-1:0]        t_cyc_o,
  output logic [NUM_TGT-1:0]        t_stb_o,
  output logic [NUM_TGT-1:0]        t_we_o,
  output logic [NUM_TGT*ADDR_W-1:0] t_adr_o,
  output logic [NUM_TGT*DATA_W-1:0] t_dat_o,
  output logic [NUM_TGT*BE_W-1:0]   t_be_o,
  input  logic [NUM_TGT-1:0]        t_ack_i,
  input  logic [NUM_TGT-1:0]        t_err_i,
  input  logic [NUM_TGT-1:0]        t_rty_i,
  input  logic [NUM_TGT*DATA_W-1:0] t_dat_i
);

  localparam int unsigned RST_STAGES = 2;

  logic               rst_int_n;
  logic [NUM_TGT-1:0] route;
  logic               term;

  demux_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  demux_sel_hold #(.NUM_TGT(NUM_TGT)) i_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cyc_i   (m_cyc_i),
    .stb_i   (m_stb_i),
    .tsel_i  (m_tsel_i),
    .term_i  (term),
    .route_o (route)
  );

  demux_fwd #(
    .NUM_TGT (NUM_TGT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BE_W    (BE_W)
  ) i_fwd (
    .cyc_i   (m_cyc_i),
    .stb_i   (m_stb_i),
    .we_i    (m_we_i),
    .adr_i   (m_adr_i),
    .dat_i   (m_dat_i),
    .be_i    (m_be_i),
    .route_i (route),
    .t_cyc_o (t_cyc_o),
    .t_stb_o (t_stb_o),
    .t_we_o  (t_we_o),
    .t_adr_o (t_adr_o),
    .t_dat_o (t_dat_o),
    .t_be_o  (t_be_o)
  );

  demux_ret #(
    .NUM_TGT (NUM_TGT),
    .DATA_W  (DATA_W)
  ) i_ret (
    .strobed_i (t_stb_o),
    .t_ack_i   (t_ack_i),
    .t_err_i   (t_err_i),
    .t_rty_i   (t_rty_i),
    .t_dat_i   (t_dat_i),
    .ack_o     (m_ack_o),
    .err_o     (m_err_o),
    .rty_o     (m_rty_o),
    .dat_o     (m_dat_o)
  );

  assign term = m_ack_o | m_err_o | m_rty_o;

endmodule

// File: rtl/demux_onehot_chk.sv
module demux_onehot_chk #(
  parameter int unsigned NUM_TGT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m_cyc_i,
  input logic               m_stb_i,
  input logic [NUM_TGT-1:0] m_tsel_i,
  input logic               m_ack_o,
  input logic               m_err_o,
  input logic               m_rty_o,
  input logic [NUM_TGT-1:0] t_cyc_o,
  input logic [NUM_TGT-1:0] t_stb_o,
  input logic [NUM_TGT-1:0] t_ack_i
);

  // Cycles since reset release, saturating; covers the reset synchroniser.
  logic [1:0] age_q;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assign settled = (age_q == 2'd3);

  logic active;
  logic term;
  assign active = m_cyc_i & m_stb_i;
  assign term   = m_ack_o | m_err_o | m_rty_o;

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_stb_o));

  assert_stb_within_cyc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_stb_o & ~t_cyc_o) == '0);

  assert_first_cycle_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && active && !$past(active) && $countones(m_tsel_i) == 1) |-> t_stb_o == m_tsel_i);

  assert_ack_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack_o == |(t_ack_i & t_stb_o));

  assert_hold_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && active && !term) |=> (active -> t_stb_o == $past(t_stb_o)));

  assert_quiet_when_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (t_stb_o == '0) |-> (!m_ack_o && !m_err_o && !m_rty_o));

endmodule

bind demux_onehot demux_onehot_chk #(.NUM_TGT(NUM_TGT)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_cyc_i  (m_cyc_i),
  .m_stb_i  (m_stb_i),
  .m_tsel_i (m_tsel_i),
  .m_ack_o  (m_ack_o),
  .m_err_o  (m_err_o),
  .m_rty_o  (m_rty_o),
  .t_cyc_o  (t_cyc_o),
  .t_stb_o  (t_stb_o),
  .t_ack_i  (t_ack_i)
);

// File: tb/test_demux_onehot.sv
module test_demux_onehot;

  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 4;

  logic              clk;
  logic              rst_n;
  logic              m_cyc, m_stb, m_we;
  logic [AW-1:0]     m_adr;
  logic [DW-1:0]     m_dat;
  logic [BW-1:0]     m_be;
  logic [N-1:0]      m_tsel;
  logic              m_ack, m_err, m_rty;
  logic [DW-1:0]     m_rdat;
  logic [N-1:0]      t_cyc, t_stb, t_we;
  logic [N*AW-1:0]   t_adr;
  logic [N*DW-1:0]   t_wdat;
  logic [N*BW-1:0]   t_be;
  logic [N-1:0]      t_ack, t_err, t_rty;
  logic [N*DW-1:0]   t_rdat;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  demux_onehot #(.NUM_TGT(N), .ADDR_W(AW), .DATA_W(DW), .BE_W(BW)) i_demux_onehot (
    .clk(clk), .rst_n(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
    .m_dat_i(m_dat), .m_be_i(m_be), .m_tsel_i(m_tsel),
    .m_ack_o(m_ack), .m_err_o(m_err), .m_rty_o(m_rty), .m_dat_o(m_rdat),
    .t_cyc_o(t_cyc), .t_stb_o(t_stb), .t_we_o(t_we), .t_adr_o(t_adr),
    .t_dat_o(t_wdat), .t_be_o(t_be),
    .t_ack_i(t_ack), .t_err_i(t_err), .t_rty_i(t_rty), .t_dat_i(t_rdat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] tgt_word(input int i, input int salt);
    return 32'h5A00_0000 + DW'(i) * 32'h0000_0101 + DW'(salt);
  endfunction

  task automatic set_rdata(input int salt);
    for (int i = 0; i < N; i++) t_rdat[i*DW +: DW] = tgt_word(i, salt);
  endtask

  task automatic idle();
    m_cyc = 0; m_stb = 0; m_we = 0; m_adr = '0; m_dat = '0; m_be = '0; m_tsel = '0;
    t_ack = '0; t_err = '0; t_rty = '0;
  endtask

  task automatic strobe(input logic [N-1:0] s);
    m_cyc = 1; m_stb = 1; m_tsel = s;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    set_rdata(0);
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R12: idle after reset
    #2;
    check("R12 t_cyc", 64'(t_cyc), 64'(0));
    check("R12 t_stb", 64'(t_stb), 64'(0));
    check("R12 resp", 64'({m_ack, m_err, m_rty}), 64'(0));

    // Sweep every select value against each response kind; all targets answer.
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 3; k++) begin
        logic [N-1:0] exp_r;
        logic [DW-1:0] exp_d;
        int idx;
        strobe(N'(v));
        m_adr = 32'h0000_1000 * AW'(v) + AW'(k);
        m_dat = ~m_adr;
        m_we  = k[0];
        m_be  = BW'(v);
        set_rdata(v * 3 + k);
        t_ack = (k == 0) ? '1 : '0;
        t_err = (k == 1) ? '1 : '0;
        t_rty = (k == 2) ? '1 : '0;
        #2;
        exp_r = ($countones(N'(v)) == 1) ? N'(v) : '0;
        idx = 0;
        for (int i = 0; i < N; i++) if (exp_r[i]) idx = i;
        exp_d = (exp_r != 0) ? tgt_word(idx, v * 3 + k) : '0;
        // R3 / R8 / R9: strobe and cycle routing in the first cycle
        check(exp_r == 0 ? "R8/R9 t_stb" : "R3 t_stb", 64'(t_stb), 64'(exp_r));
        check(exp_r == 0 ? "R8/R9 t_cyc" : "R3 t_cyc", 64'(t_cyc), 64'(exp_r));
        // R1: broadcast fields on every target
        for (int i = 0; i < N; i++) begin
          check("R1 adr", 64'(t_adr[i*AW +: AW]), 64'(m_adr));
          check("R1 wdat", 64'(t_wdat[i*DW +: DW]), 64'(m_dat));
          check("R1 be", 64'(t_be[i*BW +: BW]), 64'(m_be));
          check("R1 we", 64'(t_we[i]), 64'(m_we));
        end
        // R4 / R10: only the strobed target's response gets through
        check("R4 ack", 64'(m_ack), 64'(exp_r != 0 && k == 0));
        check("R4 err", 64'(m_err), 64'(exp_r != 0 && k == 1));
        check("R4 rty", 64'(m_rty), 64'(exp_r != 0 && k == 2));
        check(exp_r == 0 ? "R8 rdat" : "R4 rdat", 64'(m_rdat), 64'(exp_d));
        tick();
        idle();
        tick();
      end
    end

    // R5: select changes during a held strobe are ignored
    set_rdata(100);
    strobe(4'b0001);
    tick();
    m_tsel = 4'b0100;
    #2;
    check("R5 held target", 64'(t_stb), 64'(4'b0001));
    t_ack = 4'b0100;
    #1;
    check("R10 unselected ack", 64'(m_ack), 64'(0));
    tick();
    m_tsel = 4'b0000;
    t_ack = '0;
    #2;
    check("R5 held through zero", 64'(t_stb), 64'(4'b0001));
    m_tsel = 4'b0100;
    t_ack = 4'b0001;
    #1;
    check("R4 ack held", 64'(m_ack), 64'(1));
    check("R4 rdat held", 64'(m_rdat), 64'(tgt_word(0, 100)));

    // R11: stb kept high across termination picks up the live select
    tick();
    t_ack = '0;
    #2;
    check("R11 new access", 64'(t_stb), 64'(4'b0100));
    t_err = 4'b0100;
    #1;
    check("R4 err routed", 64'(m_err), 64'(1));
    tick();

    // R6: drop stb keeping cyc, then strobe a different target
    t_err = '0;
    m_stb = 0;
    m_tsel = 4'b1000;
    #2;
    check("R6 gap no stb", 64'(t_stb), 64'(0));
    tick();
    m_stb = 1;
    #2;
    check("R6 restrobe", 64'(t_stb), 64'(4'b1000));
    t_rty = 4'b1000;
    #1;
    check("R6 rty routed", 64'(m_rty), 64'(1));
    tick();

    // R7: release cyc, then a new cycle to another target
    idle();
    tick();
    strobe(4'b0010);
    #2;
    check("R7 new cycle", 64'(t_stb), 64'(4'b0010));
    check("R7 new cycle cyc", 64'(t_cyc), 64'(4'b0010));
    tick();
    m_tsel = 4'b0001;
    #2;
    check("R5 held second", 64'(t_stb), 64'(4'b0010));
    tick();
    idle();
    tick();
    #2;
    check("R12 idle again", 64'(t_cyc | t_stb), 64'(0));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule